// File: doc/BRIEF.md
# Stereo Serial Audio Master Transmitter with Odd Bit-Clock Ratio

This block drives a three-wire I2S stereo output from one master clock. It makes the bit clock by counting master-clock cycles. The fast ratio is divide-by-5, with the bit clock high for 2 cycles and low for 3. The slow ratio is divide-by-10, with 5 cycles high and 5 low. No derived clock is used inside the block. Every frame lasts 500 master-clock cycles in both ratios. A frame is two channel slots, left then right. A slot is 50 bit periods at the fast ratio and 25 at the slow ratio. The word-select line is low for the left slot and high for the right slot. It changes level during the last bit period of each slot.

Samples arrive over a valid/ready stream and go into a one-entry holding register. At each frame start the holding register moves to the active pair. If nothing is waiting, the previous pair is sent again. A one-cycle request pulse marks every frame start, so the producer can time its next sample. The ratio select is sampled only at a frame start.

Top module: `i2s_odd_tx`

## Requirements
- R1: In fast mode (`mode_slow` = 0), `bclk` repeats every 5 `mclk` cycles: high for 2, low for 3.
- R2: In slow mode (`mode_slow` = 1), `bclk` repeats every 10 `mclk` cycles: high for 5, low for 5.
- R3: A frame lasts 500 `mclk` cycles in either mode. It holds two slots of 50 bit periods (fast) or 25 bit periods (slow).
- R4: `lrck` is 0 through the left slot and 1 through the right slot. In the last bit period of a slot it already shows the level of the next slot.
- R5: Sampled at the `bclk` rising edge, bit period k of a slot (k = 0 first) carries sample bit 23-k for k < 24. This is MSB first, starting in the first period after the `lrck` change. Every later bit period of the slot carries 0.
- R6: `sdata` and `lrck` change only on the `mclk` edge where `bclk` falls.
- R7: `smp_ready` is 1 whenever the holding register is empty. A pair is accepted on a rising `mclk` edge with `smp_valid` and `smp_ready` both 1. After that `smp_ready` stays 0 until the next frame start frees the register. A producer that holds `smp_valid` high waits with its data unchanged.
- R8: The held pair is used from the frame start after it was accepted. A frame with no new pair repeats the previous left and right values.
- R9: `smp_req` is high for exactly one `mclk` cycle per frame. It is set on the edge where the first left bit is driven, with `lrck` low.
- R10: While `rst` is high, `bclk`, `lrck`, `sdata` and `smp_req` are 0 and `smp_ready` is 1. The first frame starts on the 5th `mclk` edge after release in fast mode, or the 10th in slow mode.
- R11: A change of `mode_slow` takes effect only at the next frame start. The frame in progress keeps its bit-clock timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock, 24 MHz |
| rst | input | 1 | Synchronous reset, active high |
| mode_slow | input | 1 | 0: divide-by-5, 50-bit slots; 1: divide-by-10, 25-bit slots |
| smp_valid | input | 1 | Sample pair offered |
| smp_ready | output | 1 | Holding register empty |
| smp_left | input | SW (24) | Left sample, two's complement |
| smp_right | input | SW (24) | Right sample |
| smp_req | output | 1 | One-cycle frame-start pulse |
| bclk | output | 1 | Bit clock |
| lrck | output | 1 | Word select, low = left |
| sdata | output | 1 | Serial data, MSB first |

## Verification
The bench builds the block with its default parameters: ratios 5 and 10, high phases of 2 and 5 cycles, slots of 50 and 25 bits, and 24-bit samples. These defaults make both ratios produce exactly 500-cycle frames. So the bench can switch ratios in the middle of a run and check that the switch lands on a frame start. The 50-bit slot has a 26-bit zero tail and the 25-bit slot has a single zero bit. Between them they cover the long-pad case and the case where the `lrck` change falls straight after the last sample bit.

// File: rtl/i2s_odd_pkg.sv
package i2s_odd_pkg;
  localparam int unsigned CNT_W = 8;
  typedef logic [CNT_W-1:0] cnt_t;
  typedef enum logic {MODE_FAST = 1'b0, MODE_SLOW = 1'b1} bclk_mode_e;
endpackage

// File: rtl/i2s_bclk_gen.sv
module i2s_bclk_gen
  import i2s_odd_pkg::*;
(
  input  logic mclk,
  input  logic rst,
  input  cnt_t div_act,
  input  cnt_t hi_act,
  input  cnt_t hi_nxt,
  output logic bclk,
  output logic fall
);
  cnt_t ph;
  logic rise;

  // high phase occupies ph 0..hi-1, low phase hi..div-1
  assign fall = (ph == cnt_t'(hi_act - cnt_t'(1)));
  assign rise = (ph == cnt_t'(div_act - cnt_t'(1)));

  always_ff @(posedge mclk) begin
    if (rst) begin
      ph   <= hi_nxt;
      bclk <= 1'b0;
    end else if (fall) begin
      ph   <= hi_nxt;
      bclk <= 1'b0;
    end else if (rise) begin
      ph   <= '0;
      bclk <= 1'b1;
    end else begin
      ph   <= cnt_t'(ph + cnt_t'(1));
    end
  end

  AST_HIGH_MIN: assert property (@(posedge mclk) disable iff (rst)
    $rose(bclk) |=> bclk); // R1
  AST_LOW_MIN: assert property (@(posedge mclk) disable iff (rst)
    $fell(bclk) |=> !bclk); // R2
endmodule

// File: rtl/i2s_slot_seq.sv
module i2s_slot_seq
  import i2s_odd_pkg::*;
(
  input  logic mclk,
  input  logic rst,
  input  logic fall,
  input  cnt_t slot_act,
  input  cnt_t slot_nxt,
  output logic lrck,
  output logic ch_right,
  output logic slot_start,
  output logic fs
);
  cnt_t bit_q, bit_n;
  logic last, ch_n;

  assign last       = (bit_q == cnt_t'(slot_act - cnt_t'(1)));
  assign slot_start = fall && last;
  assign fs         = slot_start && ch_right;
  assign bit_n      = last ? '0 : cnt_t'(bit_q + cnt_t'(1));
  assign ch_n       = last ? !ch_right : ch_right;

  always_ff @(posedge mclk) begin
    if (rst) begin
      bit_q    <= cnt_t'(slot_nxt - cnt_t'(1));
      ch_right <= 1'b1;
      lrck     <= 1'b0;
    end else if (fall) begin
      bit_q    <= bit_n;
      ch_right <= ch_n;
      lrck     <= (bit_n == cnt_t'(slot_nxt - cnt_t'(1))) ? !ch_n : ch_n;
    end
  end

  AST_LEFT_AT_FRAME: assert property (@(posedge mclk) disable iff (rst)
    fs |-> !lrck); // R4
  AST_BIT_IN_SLOT: assert property (@(posedge mclk) disable iff (rst)
    bit_q < slot_act); // R3
endmodule

// File: rtl/i2s_sample_buf.sv
module i2s_sample_buf #(
  parameter int unsigned SW = 24
) (
  input  logic          mclk,
  input  logic          rst,
  input  logic          fs,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [SW-1:0] in_left,
  input  logic [SW-1:0] in_right,
  output logic [SW-1:0] next_left,
  output logic [SW-1:0] cur_right
);
  logic          hold_full;
  logic [SW-1:0] hold_l, hold_r, cur_l;
  logic          acc;

  assign in_ready  = !hold_full;
  assign acc       = in_valid && in_ready;
  assign next_left = hold_full ? hold_l : cur_l;

  always_ff @(posedge mclk) begin
    if (rst) begin
      hold_full <= 1'b0;
      hold_l    <= '0;
      hold_r    <= '0;
      cur_l     <= '0;
      cur_right <= '0;
    end else begin
      hold_full <= acc || (hold_full && !fs);
      if (acc) begin
        hold_l <= in_left;
        hold_r <= in_right;
      end
      if (fs && hold_full) begin
        cur_l     <= hold_l;
        cur_right <= hold_r;
      end
    end
  end

  AST_READY_DROP: assert property (@(posedge mclk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready); // R7
  AST_HOLD_KEEP: assert property (@(posedge mclk) disable iff (rst)
    (hold_full && !fs) |=> (hold_full && $stable(hold_l) && $stable(hold_r))); // R7
  AST_REPEAT: assert property (@(posedge mclk) disable iff (rst)
    (fs && !hold_full) |=> $stable(cur_l)); // R8
endmodule

// File: rtl/i2s_shifter.sv
module i2s_shifter #(
  parameter int unsigned SW = 24
) (
  input  logic          mclk,
  input  logic          rst,
  input  logic          fall,
  input  logic          slot_start,
  input  logic [SW-1:0] word,
  output logic          sdata
);
  logic [SW-1:0] sh;

  always_ff @(posedge mclk) begin
    if (rst) begin
      sh    <= '0;
      sdata <= 1'b0;
    end else if (fall) begin
      if (slot_start) begin
        sdata <= word[SW-1];
        sh    <= {word[SW-2:0], 1'b0};
      end else begin
        sdata <= sh[SW-1];
        sh    <= {sh[SW-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/i2s_odd_tx.sv
module i2s_odd_tx
  import i2s_odd_pkg::*;
#(
  parameter int unsigned SW        = 24,
  parameter int unsigned FAST_DIV  = 5,
  parameter int unsigned FAST_HI   = 2,
  parameter int unsigned FAST_SLOT = 50,
  parameter int unsigned SLOW_DIV  = 10,
  parameter int unsigned SLOW_HI   = 5,
  parameter int unsigned SLOW_SLOT = 25
) (
  input  logic          mclk,
  input  logic          rst,
  input  logic          mode_slow,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [SW-1:0] smp_left,
  input  logic [SW-1:0] smp_right,
  output logic          smp_req,
  output logic          bclk,
  output logic          lrck,
  output logic          sdata
);
  localparam int unsigned FRAME = FAST_DIV * 2 * FAST_SLOT;
  localparam int unsigned FR_W  = $clog2(FRAME + 1);

  function automatic cnt_t div_of(input bclk_mode_e m);
    return (m == MODE_SLOW) ? cnt_t'(SLOW_DIV) : cnt_t'(FAST_DIV);
  endfunction
  function automatic cnt_t hi_of(input bclk_mode_e m);
    return (m == MODE_SLOW) ? cnt_t'(SLOW_HI) : cnt_t'(FAST_HI);
  endfunction
  function automatic cnt_t slot_of(input bclk_mode_e m);
    return (m == MODE_SLOW) ? cnt_t'(SLOW_SLOT) : cnt_t'(FAST_SLOT);
  endfunction

  bclk_mode_e    mode_act, mode_in, mode_nxt;
  logic          fall, fs, slot_start, ch_right;
  logic [SW-1:0] next_l, cur_r, word;

  assign mode_in  = bclk_mode_e'(mode_slow);
  assign mode_nxt = (fs || rst) ? mode_in : mode_act;
  assign word     = ch_right ? next_l : cur_r;

  always_ff @(posedge mclk) begin
    mode_act <= mode_nxt;
    smp_req  <= rst ? 1'b0 : fs;
  end

  i2s_bclk_gen u_bclk (
    .mclk(mclk), .rst(rst),
    .div_act(div_of(mode_act)), .hi_act(hi_of(mode_act)), .hi_nxt(hi_of(mode_nxt)),
    .bclk(bclk), .fall(fall)
  );

  i2s_slot_seq u_seq (
    .mclk(mclk), .rst(rst), .fall(fall),
    .slot_act(slot_of(mode_act)), .slot_nxt(slot_of(mode_nxt)),
    .lrck(lrck), .ch_right(ch_right), .slot_start(slot_start), .fs(fs)
  );

  i2s_sample_buf #(.SW(SW)) u_buf (
    .mclk(mclk), .rst(rst), .fs(fs),
    .in_valid(smp_valid), .in_ready(smp_ready),
    .in_left(smp_left), .in_right(smp_right),
    .next_left(next_l), .cur_right(cur_r)
  );

  i2s_shifter #(.SW(SW)) u_shift (
    .mclk(mclk), .rst(rst), .fall(fall), .slot_start(slot_start),
    .word(word), .sdata(sdata)
  );

  // frame-length watch for the assertion below
  logic [FR_W-1:0] fr_cnt;
  logic            fr_seen;
  always_ff @(posedge mclk) begin
    if (rst) begin
      fr_cnt  <= '0;
      fr_seen <= 1'b0;
    end else if (fs) begin
      fr_cnt  <= '0;
      fr_seen <= 1'b1;
    end else begin
      fr_cnt  <= FR_W'(fr_cnt + 1'b1);
    end
  end

  AST_FRAME_LEN: assert property (@(posedge mclk) disable iff (rst)
    (fs && fr_seen) |-> (fr_cnt == FR_W'(FRAME - 1))); // R3
  AST_SDATA_ON_FALL: assert property (@(posedge mclk) disable iff (rst)
    !$stable(sdata) |-> $fell(bclk)); // R6
  AST_LRCK_ON_FALL: assert property (@(posedge mclk) disable iff (rst)
    !$stable(lrck) |-> $fell(bclk)); // R6
  AST_REQ_PULSE: assert property (@(posedge mclk) disable iff (rst)
    smp_req |=> !smp_req); // R9
  AST_MODE_HOLD: assert property (@(posedge mclk) disable iff (rst)
    !fs |=> $stable(mode_act)); // R11
endmodule

// File: tb/i2s_odd_tx_tb.sv
module i2s_odd_tx_tb;
  localparam int CLK_PER = 10;
  localparam int NV = 5;
  // {mode_slow, left[23:0], right[23:0]}
  localparam logic [48:0] VECS [NV] = '{
    {1'b0, 24'hAC6B4D, 24'h296479},
    {1'b0, 24'h800001, 24'h7FFFFE},
    {1'b1, 24'hFFFFFF, 24'h000000},
    {1'b1, 24'h5A5A5A, 24'hA5A5A5},
    {1'b0, 24'h123456, 24'hFEDCBA}
  };

  logic mclk = 1'b0;
  logic rst = 1'b1;
  logic mode_slow = 1'b0;
  logic smp_valid = 1'b0;
  logic [23:0] smp_left = '0, smp_right = '0;
  logic smp_ready, smp_req, bclk, lrck, sdata;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PER/2) mclk = ~mclk;

  i2s_odd_tx u_dut (
    .mclk(mclk), .rst(rst), .mode_slow(mode_slow),
    .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_left(smp_left), .smp_right(smp_right),
    .smp_req(smp_req), .bclk(bclk), .lrck(lrck), .sdata(sdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_req();
    @(negedge mclk);
    while (!smp_req) @(negedge mclk);
  endtask

  task automatic push(input logic [23:0] l, input logic [23:0] r);
    smp_valid = 1'b1; smp_left = l; smp_right = r;
    while (!smp_ready) @(negedge mclk);
    @(negedge mclk);
    smp_valid = 1'b0;
  endtask

  task automatic meas(output int hi, output int lo);
    @(posedge bclk);
    hi = 0; lo = 0;
    @(negedge mclk);
    while (bclk)  begin hi++; @(negedge mclk); end
    while (!bclk) begin lo++; @(negedge mclk); end
  endtask

  task automatic cap(input int slot, output logic [23:0] l, output logic [23:0] r,
                     output int pad_err, output int lr_err);
    l = '0; r = '0; pad_err = 0; lr_err = 0;
    for (int i = 0; i < 2*slot; i++) begin
      int k;
      bit rside;
      logic exp_lr;
      @(posedge bclk);
      k = i % slot;
      rside = (i >= slot);
      exp_lr = (k == slot-1) ? !rside : rside;
      if (lrck !== exp_lr) lr_err++;
      if (k < 24) begin
        if (!rside) l = {l[22:0], sdata}; else r = {r[22:0], sdata};
      end else if (sdata !== 1'b0) pad_err++;
    end
  endtask

  task automatic count_frame(output int n);
    n = 0;
    @(negedge mclk); n++;
    while (!smp_req) begin @(negedge mclk); n++; end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (120000) @(posedge mclk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [23:0] gl, gr;
    int pe, le, hi, lo, n;
    bit seen;
    // reset state, fast mode
    repeat (3) @(negedge mclk);
    chk({bclk, lrck, sdata, smp_req} == 4'b0, "R10 outputs low in reset", {bclk, lrck, sdata, smp_req}, 0);
    chk(smp_ready === 1'b1, "R10 ready in reset", smp_ready, 1);
    rst = 1'b0;
    seen = 0;
    repeat (4) begin @(negedge mclk); if (smp_req) seen = 1; end
    chk(!seen, "R10 no frame start before edge 5", seen, 0);
    @(negedge mclk);
    chk(smp_req === 1'b1 && lrck === 1'b0, "R10 R9 frame start at edge 5", {smp_req, lrck}, 2'b10);
    @(negedge mclk);
    chk(smp_req === 1'b0, "R9 request is one cycle", smp_req, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic m, pm;
      int slot;
      m = VECS[i][48];
      slot = m ? 25 : 50;
      wait_req();
      push(VECS[i][47:24], VECS[i][23:0]);
      pm = mode_slow;
      mode_slow = m;
      if (m != pm) begin
        meas(hi, lo);
        chk(hi == (pm ? 5 : 2) && lo == (pm ? 5 : 3), "R11 old timing kept mid-frame",
            {hi[7:0], lo[7:0]}, {pm ? 8'd5 : 8'd2, pm ? 8'd5 : 8'd3});
      end
      wait_req();
      cap(slot, gl, gr, pe, le);
      chk(gl === VECS[i][47:24], "R5 R8 left word", gl, VECS[i][47:24]);
      chk(gr === VECS[i][23:0], "R5 R8 right word", gr, VECS[i][23:0]);
      chk(pe == 0, "R5 pad bits zero", pe, 0);
      chk(le == 0, "R4 lrck slot pattern", le, 0);
      meas(hi, lo);
      if (m) chk(hi == 5 && lo == 5, "R2 slow bclk 5/5", {hi[7:0], lo[7:0]}, 16'h0505);
      else   chk(hi == 2 && lo == 3, "R1 fast bclk 2/3", {hi[7:0], lo[7:0]}, 16'h0203);
      wait_req();
      count_frame(n);
      chk(n == 500, "R3 frame length", n, 500);
    end

    // repeat when nothing new was loaded
    wait_req();
    cap(50, gl, gr, pe, le);
    chk(gl === 24'h123456 && gr === 24'hFEDCBA, "R8 previous pair repeated", {gl, gr}, {24'h123456, 24'hFEDCBA});

    // back-pressure
    wait_req();
    smp_valid = 1'b1; smp_left = 24'h0F0F0F; smp_right = 24'hF0F0F0;
    chk(smp_ready === 1'b1, "R7 ready when empty", smp_ready, 1);
    @(negedge mclk);
    chk(smp_ready === 1'b0, "R7 ready drops after accept", smp_ready, 0);
    smp_left = 24'h3C3C3C; smp_right = 24'hC3C3C3;
    repeat (20) @(negedge mclk);
    chk(smp_ready === 1'b0, "R7 still full mid-frame", smp_ready, 0);
    wait_req();
    chk(smp_ready === 1'b1, "R7 freed at frame start", smp_ready, 1);
    @(negedge mclk);
    smp_valid = 1'b0;
    chk(smp_ready === 1'b0, "R7 second pair accepted", smp_ready, 0);
    cap(50, gl, gr, pe, le);
    chk(gl === 24'h0F0F0F && gr === 24'hF0F0F0, "R7 R8 first pair sent", {gl, gr}, {24'h0F0F0F, 24'hF0F0F0});
    wait_req();
    cap(50, gl, gr, pe, le);
    chk(gl === 24'h3C3C3C && gr === 24'hC3C3C3, "R7 R8 waiting pair sent next", {gl, gr}, {24'h3C3C3C, 24'hC3C3C3});

    // data and lrck change only where bclk falls
    begin
      int bad;
      logic pb, ps, pl;
      bad = 0;
      @(negedge mclk);
      pb = bclk; ps = sdata; pl = lrck;
      for (int j = 0; j < 600; j++) begin
        @(negedge mclk);
        if ((sdata !== ps || lrck !== pl) && !(pb === 1'b1 && bclk === 1'b0)) bad++;
        pb = bclk; ps = sdata; pl = lrck;
      end
      chk(bad == 0, "R6 changes only at bclk fall", bad, 0);
    end

    // reset in slow mode
    @(negedge mclk);
    rst = 1'b1; mode_slow = 1'b1;
    repeat (3) @(negedge mclk);
    chk({bclk, lrck, sdata, smp_req} == 4'b0, "R10 outputs cleared by reset", {bclk, lrck, sdata, smp_req}, 0);
    rst = 1'b0;
    seen = 0;
    repeat (9) begin @(negedge mclk); if (smp_req) seen = 1; end
    chk(!seen, "R10 slow no frame start before edge 10", seen, 0);
    @(negedge mclk);
    chk(smp_req === 1'b1, "R10 slow frame start at edge 10", smp_req, 1);
    cap(25, gl, gr, pe, le);
    chk(gl === 24'h0 && gr === 24'h0 && le == 0, "R10 R4 cleared samples after reset", {gl, gr}, 0);

    finish_run();
  end
endmodule